// File: doc/BRIEF.md
# Byte-Array Command Sequencer with Wake-on-Edge Sleep

This block controls a small byte-wide nonvolatile array made of equal pages, together with a shadow RAM one page in size. A host writes three registers over a simple register port: a command, a target address for byte programming and a data byte for byte programming. Writing a nonzero code to the command register starts an operation. The sequencer then programs one byte, erases one page, copies the shadow RAM into page 0, copies page 0 into the shadow RAM, or parks the block in a low-power sleep state.

Byte programming can only clear bits: the addressed cell receives the bitwise AND of its old value and the data byte. Erase returns every byte of a page to 0xFF. Multi-byte operations move one byte per clock. The command register reads back nonzero while an operation is in progress, and it clears itself when the operation completes. Sleep is left on any transition of a one-wire serial line. That line is synchronised inside the block first.

Top module: `flash_cmd_seq`

## Requirements
- R1: Command 0x0F replaces the array cell at the program address with (old value AND program data). The command register reads 0x0F for one clock after acceptance and is zero after the next clock.
- R2: Command 0x40+p, for p below the page count, writes 0xFF to all bytes of page p, one byte per clock. The other pages are left unchanged.
- R3: Command 0x45 copies shadow RAM byte i into array byte i for every i in page 0.
- R4: Command 0x48 copies array byte i of page 0 into shadow RAM byte i for every i in the page.
- R5: A multi-byte command keeps `busy` high and `cmd_reg` equal to the code for exactly PAGE_BYTES clocks after the accepting clock. Then `cmd_reg` returns to 0x00.
- R6: A write to the command register while `busy` is high is ignored. So is a host write to the shadow RAM while `busy` is high.
- R7: Any other nonzero code changes no storage and is cleared on the clock after acceptance.
- R8: Command 0xF6 with `wake_en` high raises `asleep` on the next clock. `asleep` then stays high, with `cmd_reg` holding 0xF6, until the serial line changes level.
- R9: Command 0xF6 with `wake_en` low is dropped. `cmd_reg` clears on the next clock and `asleep` never rises.
- R10: The serial line passes through two synchroniser flops. A level change of either polarity, driven before clock edge m, drops `asleep` and clears `cmd_reg` at edge m+2.
- R11: A byte-program command whose address is at or beyond the array size changes no array byte, and it is still cleared after one clock.
- R12: After reset: `cmd_reg` is 0x00, `busy` and `asleep` are low, every array byte is 0xFF and every shadow RAM byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 program address, 2 program data |
| wr_data | input | 8 | Host write data |
| ram_wr_en | input | 1 | Host shadow RAM write strobe (ignored while busy) |
| ram_wr_addr | input | $clog2(PAGE_BYTES) | Host shadow RAM write address |
| ram_wr_data | input | 8 | Host shadow RAM write data |
| ram_rd_addr | input | $clog2(PAGE_BYTES) | Shadow RAM read address |
| ram_rd_data | output | 8 | Shadow RAM read data (combinational) |
| arr_rd_addr | input | $clog2(NUM_PAGES*PAGE_BYTES) | Array read address |
| arr_rd_data | output | 8 | Array read data (combinational, 0xFF beyond the array) |
| wake_en | input | 1 | Mode condition that permits sleep |
| serial_line | input | 1 | Asynchronous one-wire line that wakes the block |
| cmd_reg | output | 8 | Current command register value |
| busy | output | 1 | Command in progress (command register nonzero) |
| asleep | output | 1 | Sleep state |

## Verification
The bench builds the block with PAGE_BYTES = 8 and NUM_PAGES = 3, which gives a 24-byte array. This makes every page walk short enough to check the array and the shadow RAM in full after each command. The 5-bit program address can then reach addresses 24 to 31, which lie outside the array, so the out-of-range program case can be exercised. The three erase codes all still decode with these values. Both wake polarities are exercised against the exact two-edge synchroniser latency.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t CMD_PROG       = 8'h0F;
  localparam byte_t CMD_ERASE_BASE = 8'h40;
  localparam byte_t CMD_RAM2PG     = 8'h45;
  localparam byte_t CMD_PG2RAM     = 8'h48;
  localparam byte_t CMD_SLEEP      = 8'hF6;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_ERASE, OP_R2P, OP_P2R, OP_SLEEP, OP_BAD
  } op_e;

  // Byte programming can only clear bits.
  function automatic byte_t prog_merge(byte_t old_v, byte_t new_v);
    return old_v & new_v;
  endfunction

  function automatic op_e decode_op(byte_t code, int pages);
    if (code == 8'h00)                                       return OP_NONE;
    if (code == CMD_PROG)                                    return OP_PROG;
    if (code == CMD_RAM2PG)                                  return OP_R2P;
    if (code == CMD_PG2RAM)                                  return OP_P2R;
    if (code == CMD_SLEEP)                                   return OP_SLEEP;
    if (int'(code) >= int'(CMD_ERASE_BASE) &&
        int'(code) <  int'(CMD_ERASE_BASE) + pages)          return OP_ERASE;
    return OP_BAD;
  endfunction
endpackage

// File: rtl/fs_wake_sync.sv
module fs_wake_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_o = sync_q ^ prev_q;
endmodule

// File: rtl/fs_store.sv
module fs_store #(
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 3,
  localparam int N  = PAGE_BYTES * NUM_PAGES,
  localparam int AW = $clog2(N),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arr_we,
  input  logic [AW-1:0] arr_waddr,
  input  logic [7:0]    arr_wdata,
  input  logic [AW-1:0] arr_raddr_a,
  output logic [7:0]    arr_rdata_a,
  input  logic [AW-1:0] arr_raddr_b,
  output logic [7:0]    arr_rdata_b,
  input  logic          ram_we,
  input  logic [PW-1:0] ram_waddr,
  input  logic [7:0]    ram_wdata,
  input  logic [PW-1:0] ram_raddr_a,
  output logic [7:0]    ram_rdata_a,
  input  logic [PW-1:0] ram_raddr_b,
  output logic [7:0]    ram_rdata_b
);
  logic [7:0] arr_q [N];
  logic [7:0] ram_q [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) arr_q[i] <= 8'hFF;
    end else if (arr_we && int'(arr_waddr) < N) begin
      arr_q[arr_waddr] <= arr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) ram_q[i] <= 8'h00;
    end else if (ram_we) begin
      ram_q[ram_waddr] <= ram_wdata;
    end
  end

  assign arr_rdata_a = (int'(arr_raddr_a) < N) ? arr_q[arr_raddr_a] : 8'hFF;
  assign arr_rdata_b = (int'(arr_raddr_b) < N) ? arr_q[arr_raddr_b] : 8'hFF;
  assign ram_rdata_a = ram_q[ram_raddr_a];
  assign ram_rdata_b = ram_q[ram_raddr_b];
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 3,
  localparam int N  = PAGE_BYTES * NUM_PAGES,
  localparam int AW = $clog2(N),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_wdata,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          wake_en,
  input  logic          wake_evt,
  input  logic [7:0]    arr_rdata,
  input  logic [7:0]    ram_rdata,
  output logic [7:0]    cmd_q,
  output logic          asleep_q,
  output logic [AW-1:0] arr_raddr,
  output logic [PW-1:0] ram_raddr,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [7:0]    arr_wdata,
  output logic          ram_we,
  output logic [PW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata,
  output logic          done_o,
  output op_e           op_o
);
  logic [PW-1:0] idx_q;
  logic          last_step;
  logic          enter_sleep;
  logic          multi_step;
  op_e           op;

  assign op        = decode_op(cmd_q, NUM_PAGES);
  assign op_o      = op;
  assign last_step = (idx_q == PW'(PAGE_BYTES - 1));
  assign arr_raddr = (op == OP_PROG) ? prog_addr : AW'(idx_q);
  assign ram_raddr = idx_q;

  always_comb begin
    arr_we      = 1'b0;
    arr_waddr   = '0;
    arr_wdata   = 8'h00;
    ram_we      = 1'b0;
    ram_waddr   = '0;
    ram_wdata   = 8'h00;
    done_o      = 1'b0;
    enter_sleep = 1'b0;
    multi_step  = 1'b0;
    if (asleep_q) begin
      done_o = wake_evt;
    end else begin
      case (op)
        OP_PROG: begin
          arr_we    = (int'(prog_addr) < N);
          arr_waddr = prog_addr;
          arr_wdata = prog_merge(arr_rdata, prog_data);
          done_o    = 1'b1;
        end
        OP_ERASE: begin
          multi_step = 1'b1;
          arr_we     = 1'b1;
          arr_waddr  = AW'((int'(cmd_q) - int'(CMD_ERASE_BASE)) * PAGE_BYTES + int'(idx_q));
          arr_wdata  = 8'hFF;
          done_o     = last_step;
        end
        OP_R2P: begin
          multi_step = 1'b1;
          arr_we     = 1'b1;
          arr_waddr  = AW'(idx_q);
          arr_wdata  = ram_rdata;
          done_o     = last_step;
        end
        OP_P2R: begin
          multi_step = 1'b1;
          ram_we     = 1'b1;
          ram_waddr  = idx_q;
          ram_wdata  = arr_rdata;
          done_o     = last_step;
        end
        OP_SLEEP: begin
          enter_sleep = wake_en;
          done_o      = !wake_en;
        end
        OP_BAD:  done_o = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= 8'h00;
      asleep_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      if (done_o)                        cmd_q <= 8'h00;
      else if (cmd_wr && cmd_q == 8'h00) cmd_q <= cmd_wdata;

      if (enter_sleep)                   asleep_q <= 1'b1;
      else if (asleep_q && wake_evt)     asleep_q <= 1'b0;

      if (done_o)                        idx_q <= '0;
      else if (multi_step)               idx_q <= idx_q + PW'(1);
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 3,
  localparam int N  = PAGE_BYTES * NUM_PAGES,
  localparam int AW = $clog2(N),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  input  logic          ram_wr_en,
  input  logic [PW-1:0] ram_wr_addr,
  input  logic [7:0]    ram_wr_data,
  input  logic [PW-1:0] ram_rd_addr,
  output logic [7:0]    ram_rd_data,
  input  logic [AW-1:0] arr_rd_addr,
  output logic [7:0]    arr_rd_data,
  input  logic          wake_en,
  input  logic          serial_line,
  output logic [7:0]    cmd_reg,
  output logic          busy,
  output logic          asleep
);
  logic [AW-1:0] prog_addr_q;
  logic [7:0]    prog_data_q;

  // Internal events brought out for the checker
  logic          wake_evt;
  logic          done_evt;
  logic          arr_we;
  logic [AW-1:0] arr_waddr;
  logic [7:0]    arr_wdata;
  logic [7:0]    arr_old;
  logic          ctl_ram_we;
  logic [PW-1:0] ctl_ram_waddr;
  logic [7:0]    ctl_ram_wdata;
  logic [AW-1:0] ctl_arr_raddr;
  logic [PW-1:0] ctl_ram_raddr;
  logic [7:0]    ctl_ram_rdata;
  logic          st_ram_we;
  logic [PW-1:0] st_ram_waddr;
  logic [7:0]    st_ram_wdata;
  op_e           cur_op;
  logic          erase_op;
  logic          prog_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr_q <= '0;
      prog_data_q <= 8'h00;
    end else if (wr_en) begin
      if (wr_sel == SEL_ADDR) prog_addr_q <= AW'(wr_data);
      if (wr_sel == SEL_DATA) prog_data_q <= wr_data;
    end
  end

  fs_wake_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (serial_line),
    .edge_o (wake_evt)
  );

  fs_ctrl #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (wr_en && wr_sel == SEL_CMD),
    .cmd_wdata (wr_data),
    .prog_addr (prog_addr_q),
    .prog_data (prog_data_q),
    .wake_en   (wake_en),
    .wake_evt  (wake_evt),
    .arr_rdata (arr_old),
    .ram_rdata (ctl_ram_rdata),
    .cmd_q     (cmd_reg),
    .asleep_q  (asleep),
    .arr_raddr (ctl_arr_raddr),
    .ram_raddr (ctl_ram_raddr),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .arr_wdata (arr_wdata),
    .ram_we    (ctl_ram_we),
    .ram_waddr (ctl_ram_waddr),
    .ram_wdata (ctl_ram_wdata),
    .done_o    (done_evt),
    .op_o      (cur_op)
  );

  assign busy     = (cmd_reg != 8'h00);
  assign erase_op = (cur_op == OP_ERASE);
  assign prog_op  = (cur_op == OP_PROG);

  // Host RAM writes only land while idle; the controller owns the RAM when busy.
  assign st_ram_we    = ctl_ram_we || (ram_wr_en && !busy);
  assign st_ram_waddr = ctl_ram_we ? ctl_ram_waddr : ram_wr_addr;
  assign st_ram_wdata = ctl_ram_we ? ctl_ram_wdata : ram_wr_data;

  fs_store #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .arr_we      (arr_we),
    .arr_waddr   (arr_waddr),
    .arr_wdata   (arr_wdata),
    .arr_raddr_a (ctl_arr_raddr),
    .arr_rdata_a (arr_old),
    .arr_raddr_b (arr_rd_addr),
    .arr_rdata_b (arr_rd_data),
    .ram_we      (st_ram_we),
    .ram_waddr   (st_ram_waddr),
    .ram_wdata   (st_ram_wdata),
    .ram_raddr_a (ctl_ram_raddr),
    .ram_rdata_a (ctl_ram_rdata),
    .ram_raddr_b (ram_rd_addr),
    .ram_rdata_b (ram_rd_data)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       wake_en,
  input logic [7:0] cmd_reg,
  input logic       busy,
  input logic       asleep,
  input logic       done_evt,
  input logic       wake_evt,
  input logic       arr_we,
  input logic [7:0] arr_wdata,
  input logic [7:0] arr_old,
  input logic       erase_op,
  input logic       prog_op
);
  a_r1_prog_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && prog_op) |-> ((arr_wdata & ~arr_old) == 8'h00));

  a_r2_erase_writes_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && erase_op) |-> (arr_wdata == 8'hFF));

  a_r5_done_clears_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (cmd_reg == 8'h00));

  a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_sel == 2'd0 && !done_evt) |=> (cmd_reg == $past(cmd_reg)));

  a_r8_sleep_entry_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(wake_en) && $past(cmd_reg) == 8'hF6));

  a_r10_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !wake_evt) |=> asleep);

  a_r10_wake_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(wake_evt));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wake_en   (wake_en),
  .cmd_reg   (cmd_reg),
  .busy      (busy),
  .asleep    (asleep),
  .done_evt  (done_evt),
  .wake_evt  (wake_evt),
  .arr_we    (arr_we),
  .arr_wdata (arr_wdata),
  .arr_old   (arr_old),
  .erase_op  (erase_op),
  .prog_op   (prog_op)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int P  = 8;
  localparam int NP = 3;
  localparam int N  = P * NP;
  localparam int AW = $clog2(N);
  localparam int PW = $clog2(P);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [7:0]    wr_data = 8'h00;
  logic          ram_wr_en = 1'b0;
  logic [PW-1:0] ram_wr_addr = '0;
  logic [7:0]    ram_wr_data = 8'h00;
  logic [PW-1:0] ram_rd_addr = '0;
  logic [7:0]    ram_rd_data;
  logic [AW-1:0] arr_rd_addr = '0;
  logic [7:0]    arr_rd_data;
  logic          wake_en = 1'b0;
  logic          serial_line = 1'b0;
  logic [7:0]    cmd_reg;
  logic          busy;
  logic          asleep;

  flash_cmd_seq #(.PAGE_BYTES(P), .NUM_PAGES(NP)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
    .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
    .wake_en(wake_en), .serial_line(serial_line),
    .cmd_reg(cmd_reg), .busy(busy), .asleep(asleep)
  );

  always #10 clk = ~clk;

  typedef struct { bit is_ram; int addr; logic [7:0] exp; string req; } item_t;
  item_t      sb_q[$];
  logic [7:0] m_arr [N];
  logic [7:0] m_ram [P];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected storage contents and compares at the read ports.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.is_ram) ram_rd_addr = PW'(it.addr); else arr_rd_addr = AW'(it.addr);
        #1;
        if (it.is_ram) check(ram_rd_data == it.exp, it.req, ram_rd_data, it.exp);
        else           check(arr_rd_data == it.exp, it.req, arr_rd_data, it.exp);
      end
    end
  end

  task automatic push_all(input string req);
    for (int i = 0; i < N; i++) sb_q.push_back('{0, i, m_arr[i], req});
    for (int i = 0; i < P; i++) sb_q.push_back('{1, i, m_ram[i], req});
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ram_wr(input int a, input logic [7:0] d);
    ram_wr_en = 1'b1; ram_wr_addr = PW'(a); ram_wr_data = d;
    @(negedge clk);
    ram_wr_en = 1'b0;
  endtask

  // Issue a command and check busy / cmd_reg over the expected number of steps.
  task automatic run_cmd(input logic [7:0] code, input int steps, input string req);
    host_wr(2'd0, code);
    check(cmd_reg == code && busy, req, cmd_reg, code);
    for (int k = 1; k < steps; k++) begin
      @(negedge clk);
      check(cmd_reg == code && busy, req, cmd_reg, code);
    end
    @(negedge clk);
    check(cmd_reg == 8'h00 && !busy, req, cmd_reg, 0);
  endtask

  task automatic sleep_cycle(input logic new_level, input string req);
    wake_en = 1'b1;
    host_wr(2'd0, 8'hF6);
    @(negedge clk);
    check(asleep == 1'b1 && cmd_reg == 8'hF6, "R8", asleep, 1);
    repeat (4) @(negedge clk);
    check(asleep == 1'b1, "R8", asleep, 1);
    host_wr(2'd0, 8'h40);               // R6: ignored while asleep
    check(cmd_reg == 8'hF6, "R6", cmd_reg, 8'hF6);
    serial_line = new_level;            // before edge m
    repeat (2) @(negedge clk);          // edges m, m+1
    check(asleep == 1'b1, req, asleep, 1);
    @(negedge clk);                     // edge m+2
    check(asleep == 1'b0 && cmd_reg == 8'h00, req, asleep, 0);
    wake_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_arr[i] = 8'hFF;
    for (int i = 0; i < P; i++) m_ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(cmd_reg == 8'h00 && !busy && !asleep, "R12", cmd_reg, 0);
    push_all("R12");

    for (int i = 0; i < P; i++) begin
      m_ram[i] = 8'(i * 8'h13 + 8'h21);
      ram_wr(i, m_ram[i]);
    end

    // R3 + R5 + R6: RAM to page 0, with a command write and a RAM write mid-run
    host_wr(2'd0, 8'h45);
    check(busy && cmd_reg == 8'h45, "R5", cmd_reg, 8'h45);
    repeat (2) @(negedge clk);
    host_wr(2'd0, 8'h40);
    check(cmd_reg == 8'h45, "R6", cmd_reg, 8'h45);
    ram_wr(0, 8'h00);
    repeat (P - 5) @(negedge clk);
    check(busy && cmd_reg == 8'h45, "R5", cmd_reg, 8'h45);
    @(negedge clk);
    check(!busy && cmd_reg == 8'h00, "R5", cmd_reg, 0);
    for (int i = 0; i < P; i++) m_arr[i] = m_ram[i];
    push_all("R3");

    // R1 byte program twice on the same cell
    host_wr(2'd1, 8'd5); host_wr(2'd2, 8'hF0);
    run_cmd(8'h0F, 1, "R1");
    m_arr[5] = m_arr[5] & 8'hF0;
    host_wr(2'd2, 8'h3C);
    run_cmd(8'h0F, 1, "R1");
    m_arr[5] = m_arr[5] & 8'h3C;
    host_wr(2'd1, 8'd10); host_wr(2'd2, 8'h5A);
    run_cmd(8'h0F, 1, "R1");
    m_arr[10] = m_arr[10] & 8'h5A;
    push_all("R1");

    // R11 out-of-range program address
    host_wr(2'd1, 8'd28); host_wr(2'd2, 8'h00);
    run_cmd(8'h0F, 1, "R11");
    push_all("R11");

    // R2 erase page 1
    run_cmd(8'h41, P, "R2");
    for (int i = P; i < 2 * P; i++) m_arr[i] = 8'hFF;
    push_all("R2");

    // R2 erase page 0 then reprogram, R4 page 0 to RAM
    run_cmd(8'h40, P, "R2");
    for (int i = 0; i < P; i++) m_arr[i] = 8'hFF;
    host_wr(2'd1, 8'd3); host_wr(2'd2, 8'h81);
    run_cmd(8'h0F, 1, "R1");
    m_arr[3] = 8'h81;
    host_wr(2'd1, 8'd7); host_wr(2'd2, 8'h18);
    run_cmd(8'h0F, 1, "R1");
    m_arr[7] = 8'h18;
    run_cmd(8'h48, P, "R4");
    for (int i = 0; i < P; i++) m_ram[i] = m_arr[i];
    push_all("R4");

    // R7 unknown codes
    run_cmd(8'h33, 1, "R7");
    run_cmd(8'h43, 1, "R7");
    push_all("R7");

    // R9 sleep without permission
    wake_en = 1'b0;
    host_wr(2'd0, 8'hF6);
    @(negedge clk);
    check(cmd_reg == 8'h00 && !asleep, "R9", cmd_reg, 0);
    @(negedge clk);
    check(!asleep, "R9", asleep, 0);

    // R8 / R10 sleep and wake on rising then falling edge
    sleep_cycle(1'b1, "R10");
    sleep_cycle(1'b0, "R10");
    push_all("R8");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule